// File: doc/BRIEF.md
# Block Address Translation Matcher

This block holds two small banks of block-translation entries, one used for instruction fetches and one for data accesses. Each entry is a pair of 32-bit words: an upper word that describes which effective-address block it covers and for which privilege levels, and a lower word that gives the physical base of the block and its protection code. An access that falls inside a valid block is translated straight to a physical address. Segment and page translation are skipped for that access.

A request (address, fetch flag, user flag, store flag) is captured on a clock edge. The lookup result is then presented combinationally from the captured request and the current entry contents. The entries of the selected bank are searched in index order, and the first matching entry decides the outcome. If that entry grants the access, the result is a hit. If it denies the access, the result is a protection fault, and later entries are not consulted. A separate output tells the next translation stage that segment-based translation must run, which happens whenever the request produced no successful hit. Entries are loaded through a simple indexed write port, one 32-bit word per cycle.

Upper word layout:
- bits 31:28 are the exact-match block tag.
- bits 27:17 are the maskable tag.
- bits 12:2 are the block-length mask.
- bit 1 is the supervisor-valid flag.
- bit 0 is the user-valid flag.

Lower word layout:
- bits 31:28 are the fixed physical base.
- bits 27:17 are the mergeable physical base.
- bits 1:0 are the protection code.

Top module: `bat_matcher`

## Requirements
- R1: While reset is asserted and after its release, every entry of both banks is cleared, so no request can match until entries are written. With no request captured, hit, fault, segWalk, physAddr and perm are all zero.
- R2: A request with reqFetch=1 searches only the instruction bank. A request with reqFetch=0 searches only the data bank.
- R3: An entry takes part in the search only if reqUser=0 and upper bit 1 is set, or reqUser=1 and upper bit 0 is set.
- R4: An entry matches when address bits 31:28 equal upper bits 31:28 exactly, and address bits 27:17 with the mask bits cleared equal upper bits 27:17. The mask is upper bits 12:2, which lines up with address bits 27:17.
- R5: For a matching entry, physAddr has four parts:
  - bits 31:28 come from lower bits 31:28.
  - bits 27:17 are (address bits 27:17 AND mask) OR lower bits 27:17.
  - bits 16:12 are copied from the address.
  - bits 11:0 are zero.
- R6: perm is {read, write, execute} in bits 2:0 and comes from lower bits 1:0. Code 00 gives 000, code 10 gives 111, and codes 01 and 11 give 101. Execute always equals read.
- R7: The permission needed depends on the access. A fetch needs execute and ignores reqStore. A non-fetch store needs write. A non-fetch load needs read.
- R8: The lowest-indexed matching entry decides the outcome. It gives hit when it grants the access and fault when it denies it. A denial never falls through to a later entry. hit and fault are never both 1.
- R9: segWalk is 1 exactly when a request was captured and hit is 0, including the fault case.
- R10: Outputs reflect the request captured at the previous rising edge and the entry contents as written at that same edge. When no match occurs, physAddr and perm are zero.
- R11: A write with wrEn=1 loads wrData into entry wrIdx of the instruction bank (wrInstr=1) or the data bank (wrInstr=0). It loads the upper word when wrUpper=1 and the lower word otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present, captured on the rising edge |
| reqFetch | input | 1 | Request is an instruction fetch |
| reqUser | input | 1 | Request is made at user privilege |
| reqStore | input | 1 | Request is a data store |
| reqAddr | input | 32 | Effective address of the request |
| wrEn | input | 1 | Entry write enable |
| wrInstr | input | 1 | Write targets the instruction bank |
| wrUpper | input | 1 | Write targets the upper word (else lower) |
| wrIdx | input | IDX_W | Entry index to write |
| wrData | input | 32 | Word to write |
| hit | output | 1 | First matching entry grants the access |
| fault | output | 1 | First matching entry denies the access |
| segWalk | output | 1 | Segment-based translation must run |
| physAddr | output | 32 | Translated address, zero if no match |
| perm | output | 3 | Permissions {read, write, execute} of the matching entry |

## Verification
The assertions check several properties on every cycle:
- hit and fault never occur together.
- segWalk always agrees with the captured request and hit.
- The outputs stay quiet when nothing matched.
- execute mirrors read.
- A translated address is page aligned and carries the request's bits 16:12.
- A granted fetch has execute permission, and a granted store has write permission.

Some behaviour can only be shown by the bench's directed and random scenarios, compared against its reference model:
- Which entry wins under priority, and that a denial blocks a later granting entry.
- Bank separation and privilege gating.
- The effect of the block-length mask on both matching and address merging.
- A write landing in the same cycle as a request.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int AW      = 32;
  localparam int TAG_HI  = 28;  // exact-match tag starts here
  localparam int TAG_LO  = 17;  // maskable tag starts here
  localparam int TAG_LW  = TAG_HI - TAG_LO;
  localparam int MASK_LO = 2;   // block-length mask position in upper word
  localparam int PG_LO   = 12;
  localparam int SV_BIT  = 1;
  localparam int UV_BIT  = 0;

  typedef struct packed {
    logic wrUpper;
    logic wrLower;
    logic wrInstr;
    logic lookValid;
    logic lookFetch;
    logic lookUser;
    logic lookStore;
  } batStrobe_t;

  // {read, write, execute}
  function automatic logic [2:0] ppToPerm(input logic [1:0] pp);
    case (pp)
      2'b00:   return 3'b000;
      2'b10:   return 3'b111;
      default: return 3'b101;
    endcase
  endfunction
endpackage

// File: rtl/bat_ctrl.sv
module bat_ctrl
  import bat_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqFetch,
  input  logic          reqUser,
  input  logic          reqStore,
  input  logic [AW-1:0] reqAddr,
  input  logic          wrEn,
  input  logic          wrInstr,
  input  logic          wrUpper,
  output batStrobe_t    strobe,
  output logic [AW-1:0] lookAddr
);
  logic validQ, fetchQ, userQ, storeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      fetchQ   <= 1'b0;
      userQ    <= 1'b0;
      storeQ   <= 1'b0;
      lookAddr <= '0;
    end else begin
      validQ   <= reqValid;
      fetchQ   <= reqFetch;
      userQ    <= reqUser;
      storeQ   <= reqStore;
      lookAddr <= reqAddr;
    end
  end

  always_comb begin
    strobe.wrUpper   = wrEn & wrUpper;
    strobe.wrLower   = wrEn & ~wrUpper;
    strobe.wrInstr   = wrInstr;
    strobe.lookValid = validQ;
    strobe.lookFetch = fetchQ;
    strobe.lookUser  = userQ;
    strobe.lookStore = storeQ;
  end
endmodule

// File: rtl/bat_datapath.sv
module bat_datapath
  import bat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  batStrobe_t       strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [AW-1:0]    wrData,
  input  logic [AW-1:0]    lookAddr,
  output logic             hit,
  output logic             fault,
  output logic             segWalk,
  output logic [AW-1:0]    physAddr,
  output logic [2:0]       perm
);
  localparam int BANKS = 2;  // index 1 = instruction bank

  logic [AW-1:0] upReg [BANKS][NUM_ENTRIES];
  logic [AW-1:0] loReg [BANKS][NUM_ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < BANKS; b++) begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          upReg[b][e] <= '0;
          loReg[b][e] <= '0;
        end
      end
    end else begin
      if (strobe.wrUpper) upReg[strobe.wrInstr][wrIdx] <= wrData;
      if (strobe.wrLower) loReg[strobe.wrInstr][wrIdx] <= wrData;
    end
  end

  logic [NUM_ENTRIES-1:0] entryMatch;
  logic [AW-1:0]          entryPa   [NUM_ENTRIES];
  logic [2:0]             entryPerm [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [AW-1:0]     upW, loW;
    logic [TAG_LW-1:0] blMask;
    logic              eligible;
    assign upW      = upReg[strobe.lookFetch][e];
    assign loW      = loReg[strobe.lookFetch][e];
    assign blMask   = upW[MASK_LO +: TAG_LW];
    assign eligible = strobe.lookUser ? upW[UV_BIT] : upW[SV_BIT];
    assign entryMatch[e] = eligible
        && (upW[AW-1:TAG_HI] == lookAddr[AW-1:TAG_HI])
        && ((lookAddr[TAG_HI-1:TAG_LO] & ~blMask) == upW[TAG_HI-1:TAG_LO]);
    assign entryPa[e] = {loW[AW-1:TAG_HI],
                         (lookAddr[TAG_HI-1:TAG_LO] & blMask) | loW[TAG_HI-1:TAG_LO],
                         lookAddr[TAG_LO-1:PG_LO],
                         {PG_LO{1'b0}}};
    assign entryPerm[e] = ppToPerm(loW[1:0]);
  end

  logic          found, allowed;
  logic [AW-1:0] selPa;
  logic [2:0]    selPerm;

  always_comb begin
    found   = 1'b0;
    selPa   = '0;
    selPerm = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && entryMatch[i]) begin
        found   = 1'b1;
        selPa   = entryPa[i];
        selPerm = entryPerm[i];
      end
    end
    if (strobe.lookFetch)      allowed = selPerm[0];
    else if (strobe.lookStore) allowed = selPerm[1];
    else                       allowed = selPerm[2];

    hit      = strobe.lookValid & found & allowed;
    fault    = strobe.lookValid & found & ~allowed;
    segWalk  = strobe.lookValid & ~hit;
    physAddr = (strobe.lookValid & found) ? selPa : '0;
    perm     = (strobe.lookValid & found) ? selPerm : 3'b000;
  end
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
  import bat_pkg::*;
#(
  parameter int  NUM_ENTRIES = 4,
  localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqFetch,
  input  logic             reqUser,
  input  logic             reqStore,
  input  logic [31:0]      reqAddr,
  input  logic             wrEn,
  input  logic             wrInstr,
  input  logic             wrUpper,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [31:0]      wrData,
  output logic             hit,
  output logic             fault,
  output logic             segWalk,
  output logic [31:0]      physAddr,
  output logic [2:0]       perm
);
  batStrobe_t    strobe;
  logic [AW-1:0] lookAddr;

  bat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqFetch(reqFetch), .reqUser(reqUser),
    .reqStore(reqStore), .reqAddr(reqAddr),
    .wrEn(wrEn), .wrInstr(wrInstr), .wrUpper(wrUpper),
    .strobe(strobe), .lookAddr(lookAddr)
  );

  bat_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrIdx(wrIdx), .wrData(wrData), .lookAddr(lookAddr),
    .hit(hit), .fault(fault), .segWalk(segWalk),
    .physAddr(physAddr), .perm(perm)
  );
endmodule

// File: rtl/bat_matcher_checker.sv
module bat_matcher_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqFetch,
  input logic        reqStore,
  input logic [31:0] reqAddr,
  input logic        hit,
  input logic        fault,
  input logic        segWalk,
  input logic [31:0] physAddr,
  input logic [2:0]  perm
);
  assert_hit_fault_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && fault));

  assert_seg_walk_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (segWalk == ($past(reqValid) && !hit)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(reqValid)) |-> (!hit && !fault && !segWalk));

  assert_nomatch_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!hit && !fault) |-> (perm == 3'b000 && physAddr == 32'h0));

  assert_exec_mirrors_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    perm[0] == perm[2]);

  assert_page_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (hit || fault)) |->
      (physAddr[11:0] == 12'h0 && physAddr[16:12] == $past(reqAddr[16:12])));

  assert_fetch_exec_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && hit && $past(reqFetch)) |-> perm[0]);

  assert_store_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && hit && $past(reqStore) && !$past(reqFetch)) |-> perm[1]);
endmodule

bind bat_matcher bat_matcher_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFetch(reqFetch),
  .reqStore(reqStore), .reqAddr(reqAddr), .hit(hit), .fault(fault),
  .segWalk(segWalk), .physAddr(physAddr), .perm(perm)
);

// File: tb/sim_bat_matcher.sv
`timescale 1ns/1ps
module sim_bat_matcher;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqFetch = 0, reqUser = 0, reqStore = 0;
  logic [31:0] reqAddr = '0;
  logic        wrEn = 0, wrInstr = 0, wrUpper = 0;
  logic [1:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        hit, fault, segWalk;
  logic [31:0] physAddr;
  logic [2:0]  perm;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bat_matcher #(.NUM_ENTRIES(N)) u0 (.*);

  // reference model state
  longint unsigned mUp [2][N];
  longint unsigned mLo [2][N];
  bit mValid, mFetch, mUser, mStore;
  longint unsigned mAddr;

  task automatic check(string tag, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelEval(output bit eh, output bit ef, output bit es,
                           output longint unsigned epa, output int eperm);
    bit found = 0;
    int b = mFetch ? 1 : 0;
    longint unsigned pa = 0;
    int pm = 0;
    for (int i = 0; i < N; i++) begin
      longint unsigned u = mUp[b][i];
      longint unsigned l = mLo[b][i];
      longint unsigned msk = (u >> 2) & 'h7FF;
      longint unsigned ok = mUser ? (u & 1) : ((u >> 1) & 1);
      if (!found && ok != 0 && (u >> 28) == (mAddr >> 28) &&
          (((mAddr >> 17) & 'h7FF) & ~msk) == ((u >> 17) & 'h7FF)) begin
        int pp = int'(l & 3);
        found = 1;
        pa = ((l >> 28) << 28) |
             (((((mAddr >> 17) & 'h7FF) & msk) | ((l >> 17) & 'h7FF)) << 17) |
             (mAddr & 'h1F000);
        pm = (pp == 0) ? 0 : (pp == 2) ? 7 : 5;
      end
    end
    begin
      bit need;
      if (mFetch)      need = pm[0];
      else if (mStore) need = pm[1];
      else             need = pm[2];
      eh  = mValid && found && need;
      ef  = mValid && found && !need;
      es  = mValid && !eh;
      epa = (mValid && found) ? pa : 0;
      eperm = (mValid && found) ? pm : 0;
    end
  endtask

  task automatic compareAll(string tag);
    bit eh, ef, es;
    longint unsigned epa;
    int eperm;
    modelEval(eh, ef, es, epa, eperm);
    check(tag, "hit R8", hit, eh);
    check(tag, "fault R8", fault, ef);
    check(tag, "segWalk R9", segWalk, es);
    check(tag, "physAddr R5", physAddr, epa);
    check(tag, "perm R6", perm, eperm);
  endtask

  // drive at negedge, advance one edge, update model, compare at next negedge
  task automatic step(string tag, bit v, bit f, bit u, bit s, logic [31:0] a,
                      bit we, bit wi, bit wu, int idx, logic [31:0] d);
    reqValid = v; reqFetch = f; reqUser = u; reqStore = s; reqAddr = a;
    wrEn = we; wrInstr = wi; wrUpper = wu; wrIdx = 2'(idx); wrData = d;
    @(posedge clk);
    #1;
    if (we) begin
      if (wu) mUp[wi][idx] = d; else mLo[wi][idx] = d;
    end
    mValid = v; mFetch = f; mUser = u; mStore = s; mAddr = a;
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic wr(string tag, bit instr, bit upper, int idx, logic [31:0] d);
    step(tag, 0, 0, 0, 0, 32'h0, 1, instr, upper, idx, d);
  endtask

  task automatic rq(string tag, bit f, bit u, bit s, logic [31:0] a);
    step(tag, 1, f, u, s, a, 0, 0, 0, 0, 32'h0);
  endtask

  task automatic expectOut(string tag, bit h, bit f, bit s, logic [31:0] pa, logic [2:0] pm);
    check(tag, "hit", hit, h);
    check(tag, "fault", fault, f);
    check(tag, "segWalk", segWalk, s);
    check(tag, "physAddr", physAddr, pa);
    check(tag, "perm", perm, pm);
  endtask

  function automatic logic [31:0] upW(int hi, int lo, int bl, bit sv, bit uv);
    return (32'(hi) << 28) | (32'(lo) << 17) | (32'(bl) << 2) | (32'(sv) << 1) | 32'(uv);
  endfunction

  function automatic logic [31:0] loW(int hi, int lo, int pp);
    return (32'(hi) << 28) | (32'(lo) << 17) | 32'(pp);
  endfunction

  initial begin
    #(20.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < N; i++) begin mUp[b][i] = 0; mLo[b][i] = 0; end
    mValid = 0; mFetch = 0; mUser = 0; mStore = 0; mAddr = 0;
    repeat (3) @(negedge clk);
    expectOut("R1 in reset", 0, 0, 0, 32'h0, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    expectOut("R1 after reset", 0, 0, 0, 32'h0, 3'b000);
    rq("R1 empty banks", 0, 0, 0, 32'h1001_5000);
    expectOut("R1 empty banks", 0, 0, 1, 32'h0, 3'b000);

    // R11: load data entry 0 (supervisor only, RW)
    wr("R11", 0, 1, 0, upW(1, 0, 0, 1, 0));
    wr("R11", 0, 0, 0, loW(8, 0, 2));
    rq("R11 R5 load", 0, 0, 0, 32'h1001_5000);
    expectOut("R5 sup load", 1, 0, 0, 32'h8001_5000, 3'b111);
    rq("R3 user", 0, 1, 0, 32'h1001_5000);
    expectOut("R3 user blocked", 0, 0, 1, 32'h0, 3'b000);
    rq("R2 fetch", 1, 0, 0, 32'h1001_5000);
    expectOut("R2 instr bank empty", 0, 0, 1, 32'h0, 3'b000);
    rq("R7 store", 0, 0, 1, 32'h1001_5000);
    expectOut("R7 store rw", 1, 0, 0, 32'h8001_5000, 3'b111);

    // R4: block-length mask on bits 18:17
    wr("R4", 0, 1, 0, upW(1, 0, 3, 1, 0));
    rq("R4 masked", 0, 0, 0, 32'h1006_3000);
    expectOut("R4 masked hit", 1, 0, 0, 32'h8006_3000, 3'b111);
    rq("R4 outside", 0, 0, 0, 32'h1008_0000);
    expectOut("R4 outside mask", 0, 0, 1, 32'h0, 3'b000);

    // R8: priority, denial does not fall through
    wr("R8", 0, 1, 1, upW(1, 0, 0, 1, 1));
    wr("R8", 0, 0, 1, loW(9, 0, 2));
    wr("R8", 0, 0, 0, loW(8, 0, 1));
    rq("R8 store ro", 0, 0, 1, 32'h1000_2000);
    expectOut("R8 first denies", 0, 1, 1, 32'h8000_2000, 3'b101);
    rq("R8 load", 0, 0, 0, 32'h1000_2000);
    expectOut("R8 first grants", 1, 0, 0, 32'h8000_2000, 3'b101);
    rq("R3 user skip", 0, 1, 0, 32'h1000_2000);
    expectOut("R3 user next entry", 1, 0, 0, 32'h9000_2000, 3'b111);

    // R6: protection codes 00 and 11
    wr("R6", 0, 0, 0, loW(8, 0, 0));
    rq("R6 pp00", 0, 0, 0, 32'h1000_2000);
    expectOut("R6 pp00", 0, 1, 1, 32'h8000_2000, 3'b000);
    wr("R6", 0, 0, 0, loW(8, 0, 3));
    rq("R6 pp11 load", 0, 0, 0, 32'h1000_2000);
    expectOut("R6 pp11 load", 1, 0, 0, 32'h8000_2000, 3'b101);
    rq("R6 pp11 store", 0, 0, 1, 32'h1000_2000);
    expectOut("R6 pp11 store", 0, 1, 1, 32'h8000_2000, 3'b101);

    // R2 / R7: instruction bank
    wr("R2", 1, 1, 2, upW(2, 0, 0, 0, 1));
    wr("R2", 1, 0, 2, loW(4, 0, 2));
    rq("R7 fetch store flag", 1, 1, 1, 32'h2000_1000);
    expectOut("R7 fetch ignores store", 1, 0, 0, 32'h4000_1000, 3'b111);
    rq("R2 data side", 0, 1, 0, 32'h2000_1000);
    expectOut("R2 data bank separate", 0, 0, 1, 32'h0, 3'b000);
    wr("R7", 1, 0, 2, loW(4, 0, 0));
    rq("R7 fetch noexec", 1, 1, 0, 32'h2000_1000);
    expectOut("R7 fetch denied", 0, 1, 1, 32'h4000_1000, 3'b000);

    // R10: write and request in the same cycle
    step("R10 same cycle", 1, 1, 1, 0, 32'h2000_1000, 1, 1, 0, 2, loW(4, 0, 2));
    expectOut("R10 same cycle", 1, 0, 0, 32'h4000_1000, 3'b111);
    step("R10 idle", 0, 1, 1, 0, 32'h2000_1000, 0, 0, 0, 0, 32'h0);
    expectOut("R10 idle", 0, 0, 0, 32'h0, 3'b000);

    // random mix against the model
    for (int k = 0; k < 600; k++) begin
      int r = int'($urandom % 4);
      if (r == 0) begin
        bit upper = 1'($urandom);
        logic [31:0] d;
        if (upper) d = upW(1 + int'($urandom % 2), int'($urandom % 4), int'($urandom % 4),
                           1'($urandom), 1'($urandom));
        else       d = loW(int'($urandom % 16), int'($urandom % 8), int'($urandom % 4));
        step("R11 random", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             (32'(1 + $urandom % 2) << 28) | ($urandom & 32'h00FF_F000),
             1, 1'($urandom), upper, int'($urandom % N), d);
      end else begin
        rq("R4 random", 1'($urandom), 1'($urandom), 1'($urandom),
           (32'(1 + $urandom % 2) << 28) | ($urandom & 32'h00FF_F000));
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule